// File: doc/BRIEF.md
# Shared-Bus 8-bit Processor Datapath

This block holds the storage and arithmetic of a small multi-cycle 8-bit processor. Eight general registers, an instruction register, an ALU operand latch and an ALU result register all hang off one 8-bit bus. Exactly one source drives that bus in any cycle: a general register, the result register, or the external data input. A one-hot select vector picks the source.

Every register has its own load enable and samples the bus on the rising clock edge. The ALU takes one operand from the latched operand register and the other from the bus. It adds or subtracts them, and its output is captured only by the result register. A separate sequencer, outside this block, supplies every select, enable and the add/subtract control. It reads the instruction register through a dedicated output.

A typical arithmetic step uses three bus cycles. First one operand is moved into the operand latch. Next the second operand is placed on the bus while the result register captures the sum or difference. Finally the result is routed from the result register back over the bus to a destination register.

Top module: `busproc_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight general registers, the instruction register, the operand latch and the result register to zero.
- R2: Select encoding: `src_sel[i]` for i in 0..7 places general register i on the bus, `src_sel[8]` places the result register, `src_sel[9]` places `din`. The bus value is visible on `bus_out` in the same cycle. At most one select bit is set at a time.
- R3: When no bit of `src_sel` is set, `bus_out` is zero.
- R4: General register i loads the bus at a rising edge only when `gpr_we[i]` is high. Every general register whose enable is low keeps its value.
- R5: The instruction register loads the bus when `ir_we` is high and otherwise holds. Its content is shown on `ir_out`.
- R6: The operand latch loads the bus when `a_we` is high and otherwise holds. A later ALU result still uses the held value.
- R7: With `alu_sub` = 0 and `b_we` high, the result register captures (operand latch + bus) modulo 256. With `b_we` low, it holds.
- R8: With `alu_sub` = 1 and `b_we` high, the result register captures (operand latch − bus) modulo 256. A negative difference wraps.
- R9: A register-to-register move completes in one cycle. This includes a register sourcing itself and the result register being written back into a general register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | External data input, a bus source |
| src_sel | input | 10 | One-hot bus source select (bits 0..7 general registers, 8 result register, 9 din) |
| gpr_we | input | 8 | Per-register load enables for the general registers |
| ir_we | input | 1 | Instruction register load enable |
| a_we | input | 1 | Operand latch load enable |
| b_we | input | 1 | Result register load enable |
| alu_sub | input | 1 | ALU control: 0 add, 1 subtract |
| bus_out | output | 8 | Current bus value |
| ir_out | output | 8 | Instruction register content |

## Verification
The hardest state to reach from the ports is the operand latch, because it has no read path of its own. Its content can only be inferred through a later ALU result that has been routed back over the bus. The stimulus therefore loads the latch and then drives unrelated bus traffic with the latch enable low. It then computes a sum and a difference against a known register, reads the result register back over the bus, and compares both values. A wrapping subtraction and a reset in the middle of the run are checked in the same way: after the reset, adding a known `din` value shows that the latch has cleared.

// File: rtl/busproc_datapath.sv
module busproc_datapath #(
  parameter int W    = 8,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  input  logic [NREG+1:0] src_sel,
  input  logic [NREG-1:0] gpr_we,
  input  logic            ir_we,
  input  logic            a_we,
  input  logic            b_we,
  input  logic            alu_sub,
  output logic [W-1:0]    bus_out,
  output logic [W-1:0]    ir_out
);
  localparam int SEL_B   = NREG;
  localparam int SEL_DIN = NREG + 1;

  logic [W-1:0] gpr [NREG];
  logic [W-1:0] ir_q, a_q, b_q, bus, alu_y;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NREG; i++)
      if (src_sel[i]) bus = bus | gpr[i];
    if (src_sel[SEL_B])   bus = bus | b_q;
    if (src_sel[SEL_DIN]) bus = bus | din;
  end

  assign alu_y   = alu_sub ? (a_q - bus) : (a_q + bus);
  assign bus_out = bus;
  assign ir_out  = ir_q;

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk)
      if (rst)            gpr[g] <= '0;
      else if (gpr_we[g]) gpr[g] <= bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      if (ir_we) ir_q <= bus;
      if (a_we)  a_q  <= bus;
      if (b_we)  b_q  <= alu_y;
    end
  end
endmodule

// File: rtl/busproc_datapath_chk.sv
module busproc_datapath_chk #(
  parameter int W    = 8,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    din,
  input logic [NREG+1:0] src_sel,
  input logic            ir_we,
  input logic            a_we,
  input logic            b_we,
  input logic            alu_sub,
  input logic [W-1:0]    bus_out,
  input logic [W-1:0]    ir_q,
  input logic [W-1:0]    a_q,
  input logic [W-1:0]    b_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (ir_q == '0 && a_q == '0 && b_q == '0)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(src_sel)); // R2
  AST_DIN_ROUTE: assert property (@(posedge clk) disable iff (rst) (src_sel == (NREG+2)'(1) << (NREG+1)) |-> bus_out == din); // R2
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst) (src_sel == '0) |-> bus_out == '0); // R3
  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (rst) ir_we |=> ir_q == $past(bus_out)); // R5
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst) !a_we |=> $stable(a_q)); // R6
  AST_B_ADD: assert property (@(posedge clk) disable iff (rst) (b_we && !alu_sub) |=> b_q == $past(W'(a_q + bus_out))); // R7
  AST_B_SUB: assert property (@(posedge clk) disable iff (rst) (b_we && alu_sub) |=> b_q == $past(W'(a_q - bus_out))); // R8
endmodule

bind busproc_datapath busproc_datapath_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .din(din), .src_sel(src_sel), .ir_we(ir_we),
  .a_we(a_we), .b_we(b_we), .alu_sub(alu_sub), .bus_out(bus_out),
  .ir_q(ir_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/busproc_datapath_tb_top.sv
module busproc_datapath_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] din = 0;
  logic [9:0] src_sel = 0;
  logic [7:0] gpr_we = 0;
  logic       ir_we = 0, a_we = 0, b_we = 0, alu_sub = 0;
  logic [7:0] bus_out, ir_out;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         isir_q[$];
  event       chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  busproc_datapath dut_i (
    .clk(clk), .rst(rst), .din(din), .src_sel(src_sel), .gpr_we(gpr_we),
    .ir_we(ir_we), .a_we(a_we), .b_we(b_we), .alu_sub(alu_sub),
    .bus_out(bus_out), .ir_out(ir_out)
  );

  task automatic drive(input logic [9:0] sel, input logic [7:0] gwe, input logic irw,
                       input logic aw, input logic bw, input logic sub, input logic [7:0] d);
    @(negedge clk);
    src_sel = sel; gpr_we = gwe; ir_we = irw; a_we = aw; b_we = bw; alu_sub = sub; din = d;
  endtask

  task automatic push(input logic [7:0] e, input bit is_ir, input string tag);
    #1;
    exp_q.push_back(e); isir_q.push_back(is_ir); tag_q.push_back(tag);
    ->chk_ev;
    #0;
  endtask

  task automatic load_reg(input int i, input logic [7:0] v);
    drive(10'h200, 8'(1 << i), 0, 0, 0, 0, v);
  endtask

  task automatic read_reg(input int i, input logic [7:0] e, input string tag);
    drive(10'(1 << i), 0, 0, 0, 0, 0, 0);
    push(e, 0, tag);
  endtask

  task automatic read_b(input logic [7:0] e, input string tag);
    drive(10'h100, 0, 0, 0, 0, 0, 0);
    push(e, 0, tag);
  endtask

  task automatic check_ir(input logic [7:0] e, input string tag);
    drive(10'h000, 0, 0, 0, 0, 0, 0);
    push(e, 1, tag);
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e, act;
        bit         is_ir;
        string      tag;
        e = exp_q.pop_front(); is_ir = isir_q.pop_front(); tag = tag_q.pop_front();
        act = is_ir ? ir_out : bus_out;
        n_run++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", tag, act, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int i = 0; i < 8; i++) read_reg(i, 8'h00, "R1 gpr after reset");
    read_b(8'h00, "R1 result reg after reset");
    check_ir(8'h00, "R1 ir after reset");
    // R4 loads, R2 register routing
    for (int i = 0; i < 8; i++) load_reg(i, 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) read_reg(i, 8'(8'h11 * (i + 1)), "R4 R2 gpr load and route");
    // R3 idle bus
    drive(10'h000, 0, 0, 0, 0, 0, 8'hAA);
    push(8'h00, 0, "R3 idle bus");
    // R2 din routing
    drive(10'h200, 0, 0, 0, 0, 0, 8'h5A);
    push(8'h5A, 0, "R2 din route");
    // R4 enable low holds
    drive(10'h200, 8'h00, 0, 0, 0, 0, 8'hFF);
    read_reg(3, 8'h44, "R4 hold with enable low");
    load_reg(2, 8'hC3);
    read_reg(1, 8'h22, "R4 neighbour unaffected");
    read_reg(2, 8'hC3, "R4 single enable");
    // R9 moves
    drive(10'(1 << 3), 8'(1 << 5), 0, 0, 0, 0, 0);
    read_reg(5, 8'h44, "R9 move R3 to R5");
    drive(10'(1 << 6), 8'(1 << 6), 0, 0, 0, 0, 0);
    read_reg(6, 8'h77, "R9 self move");
    // R5 instruction register
    drive(10'h200, 0, 1, 0, 0, 0, 8'h9D);
    check_ir(8'h9D, "R5 ir load");
    drive(10'h200, 0, 0, 0, 0, 0, 8'h12);
    check_ir(8'h9D, "R5 ir hold");
    // R7 R8 ALU
    load_reg(1, 8'hF0);
    load_reg(2, 8'h25);
    drive(10'(1 << 1), 0, 0, 1, 0, 0, 0);
    drive(10'(1 << 2), 0, 0, 0, 1, 0, 0);
    read_b(8'h15, "R7 add wraps");
    drive(10'(1 << 2), 0, 0, 0, 1, 1, 0);
    read_b(8'hCB, "R8 subtract");
    // R6 latch holds under unrelated bus traffic
    drive(10'h200, 0, 0, 0, 0, 0, 8'h01);
    drive(10'(1 << 2), 0, 0, 0, 1, 0, 0);
    read_b(8'h15, "R6 latch hold");
    // R8 negative wrap
    drive(10'h200, 0, 0, 1, 0, 0, 8'h10);
    drive(10'(1 << 2), 0, 0, 0, 1, 1, 0);
    read_b(8'hEB, "R8 negative wrap");
    // R7 result reg holds with b_we low
    drive(10'(1 << 2), 0, 0, 0, 0, 0, 0);
    read_b(8'hEB, "R7 result hold");
    // R9 writeback of result register
    drive(10'h100, 8'(1 << 7), 0, 0, 0, 0, 0);
    read_reg(7, 8'hEB, "R9 result writeback");
    // R1 reset mid run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    read_reg(7, 8'h00, "R1 gpr cleared mid run");
    read_reg(2, 8'h00, "R1 gpr cleared mid run");
    read_b(8'h00, "R1 result cleared mid run");
    check_ir(8'h00, "R1 ir cleared mid run");
    drive(10'h200, 0, 0, 0, 1, 0, 8'h07);
    read_b(8'h07, "R1 latch cleared mid run");
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule